// File: doc/BRIEF.md
# Dual-Buffer Instruction Prefetch Unit

This front-end block fetches instruction words from memory ahead of the decoder. It holds them in two queues. The fall-through queue is filled from consecutive addresses and feeds the decoder in normal running.

When the decoder reports a conditional branch, fall-through fetching pauses. The unit then fills a second queue speculatively, starting at the branch target. The decoder keeps consuming fall-through words meanwhile. When the branch outcome arrives, one of the two queues is thrown away:
- A taken outcome discards the fall-through words. The decoder is then served from the target queue, and fall-through fetching restarts just after the last target word requested.
- A not-taken outcome discards the target words. Fall-through fetching continues from where it paused.

An unconditional jump discards everything and fetches the target at once. The decoder output stays empty until that word returns.

The memory side allows a single request in flight, with any response latency. Each request carries a generation tag for the queue it fills. A response whose queue was flushed after the request left is dropped silently.

Top module: `prefetch_dual_buf`

## Requirements
- R1: After reset, requests go to consecutive word addresses starting at RESET_ADDR. The decoder receives each word in address order, with dec_addr equal to its fetch address and dec_data equal to the memory response for that address.
- R2: A branch notice with br_cond=1 is accepted when no conditional branch is pending and no target words are still being handed to the decoder. Once it is accepted:
  - the next requests go to br_target, br_target+1, and so on, up to TGT_DEPTH words;
  - no fall-through request is made until the outcome arrives;
  - the decoder keeps receiving the fall-through words already buffered.
- R3: A taken outcome (res_valid=1, res_taken=1) on a pending conditional branch discards all buffered fall-through words. The decoder next receives the target words in order, followed by words starting at br_target plus the number of target words requested.
- R4: A not-taken outcome (res_valid=1, res_taken=0) on a pending conditional branch discards all target words. The decoder continues with the fall-through words, and fetching resumes at the address where it paused.
- R5: A branch notice with br_cond=0, accepted when no conditional branch is pending, discards both queues. Its effects:
  - the next request is br_target;
  - dec_valid stays 0 until that word has returned.
- R6: At most one memory request is outstanding. A request is accepted on a cycle with mem_req_valid=1 and mem_req_ready=1, and a further request is raised only after mem_rsp_valid has returned the previous one.
- R7: No request is made for a queue that already holds its full depth (SEQ_DEPTH or TGT_DEPTH words). Fetching into that queue resumes once the decoder frees a slot.
- R8: A response to a request issued before its queue was flushed is dropped. It never reaches the decoder.
- R9: A resolve pulse with no conditional branch pending has no effect. A branch notice of either kind arriving while a conditional branch is pending has no effect.
- R10: During and right after reset, dec_valid is 0, and the first request raised is for RESET_ADDR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req_valid | output | 1 | Fetch request present |
| mem_req_addr | output | AW | Word address of the fetch |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_rsp_valid | input | 1 | Response word present |
| mem_rsp_data | input | DW | Response word |
| br_valid | input | 1 | Branch notice from the decoder |
| br_cond | input | 1 | 1 = conditional branch, 0 = unconditional jump |
| br_target | input | AW | Branch target word address |
| res_valid | input | 1 | Outcome of the pending conditional branch |
| res_taken | input | 1 | 1 = taken, 0 = not taken |
| dec_valid | output | 1 | A word is offered to the decoder |
| dec_addr | output | AW | Address of the offered word |
| dec_data | output | DW | Offered instruction word |
| dec_pop | input | 1 | Decoder consumes the offered word |

## Verification
Some behaviour is checked by the bound checker on every cycle:
- the single-request rule;
- queue occupancy never exceeding its depth;
- the first request after a conditional notice or a jump pointing at the target;
- the decoder output being held empty right after a jump;
- the discarded queue being empty right after each kind of outcome.

Other behaviour can only be shown by the bench's scenarios, since each depends on a whole sequence of events:
- the exact order of words handed to the decoder across a taken or a not-taken outcome;
- the restart address after the target words;
- the dropping of a stale response after a jump;
- the effect of ignored notices and resolves.

// File: rtl/pfu_pkg.sv
package pfu_pkg;

  typedef enum logic {
    SRC_FALL = 1'b0,
    SRC_TGT  = 1'b1
  } pfu_src_e;

  function automatic logic pfu_has_room(input int unsigned used, input int unsigned depth);
    return used < depth;
  endfunction

endpackage

// File: rtl/pfu_fifo.sv
module pfu_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 48,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic          empty
);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] ptr_step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty   = (count == '0);
  assign do_push = push && !flush && (count != CW'(DEPTH));
  assign do_pop  = pop && !flush && !empty;
  assign head    = slots[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_step(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_step(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slots[wr_ptr] <= push_data;
  end

endmodule

// File: rtl/pfu_fetch.sv
module pfu_fetch #(
  parameter int AW = 16,
  parameter int EW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          use_tgt,
  input  logic          fall_room,
  input  logic          tgt_room,
  input  logic [AW-1:0] fall_addr,
  input  logic [AW-1:0] tgt_addr,
  input  logic [EW-1:0] fall_gen,
  input  logic [EW-1:0] tgt_gen,
  input  logic          flush_fall,
  input  logic          flush_tgt,
  input  logic          mem_req_ready,
  input  logic          mem_rsp_valid,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  output logic          req_fire,
  output logic          fire_tgt,
  output logic          busy,
  output logic          busy_tgt,
  output logic [AW-1:0] rsp_addr,
  output logic          wr_fall,
  output logic          wr_tgt
);

  import pfu_pkg::*;

  logic [EW-1:0] busy_gen;
  logic          rsp_live;
  pfu_src_e      pick;

  assign pick          = use_tgt ? SRC_TGT : SRC_FALL;
  assign mem_req_valid = !busy && ((pick == SRC_TGT) ? tgt_room : fall_room);
  assign mem_req_addr  = (pick == SRC_TGT) ? tgt_addr : fall_addr;
  assign req_fire      = mem_req_valid && mem_req_ready;
  assign fire_tgt      = req_fire && (pick == SRC_TGT);

  assign rsp_live = mem_rsp_valid && busy;
  assign wr_fall  = rsp_live && !busy_tgt && (busy_gen == fall_gen) && !flush_fall;
  assign wr_tgt   = rsp_live &&  busy_tgt && (busy_gen == tgt_gen)  && !flush_tgt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      busy_tgt <= 1'b0;
      busy_gen <= '0;
      rsp_addr <= '0;
    end else begin
      if (rsp_live) busy <= 1'b0;
      if (req_fire) begin
        busy     <= 1'b1;
        busy_tgt <= (pick == SRC_TGT);
        busy_gen <= (pick == SRC_TGT) ? tgt_gen : fall_gen;
        rsp_addr <= mem_req_addr;
      end
    end
  end

endmodule

// File: rtl/prefetch_dual_buf.sv
module prefetch_dual_buf #(
  parameter int          AW         = 16,
  parameter int          DW         = 32,
  parameter int          SEQ_DEPTH  = 4,
  parameter int          TGT_DEPTH  = 4,
  parameter int          EPOCH_W    = 3,
  parameter logic [15:0] RESET_ADDR = 16'h0000,
  localparam int         EW_ENT     = AW + DW,
  localparam int         SCW        = $clog2(SEQ_DEPTH + 1),
  localparam int         TCW        = $clog2(TGT_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_req_ready,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  input  logic          br_valid,
  input  logic          br_cond,
  input  logic [AW-1:0] br_target,
  input  logic          res_valid,
  input  logic          res_taken,
  output logic          dec_valid,
  output logic [AW-1:0] dec_addr,
  output logic [DW-1:0] dec_data,
  input  logic          dec_pop
);

  import pfu_pkg::*;

  // control state
  logic               cond_pend, drain_tgt, jump_wait;
  logic [AW-1:0]      fall_addr, tgt_addr, fall_addr_nxt, tgt_addr_nxt;
  logic [EPOCH_W-1:0] fall_gen, tgt_gen;

  // named events, also watched by the checker
  logic cond_acc, jump_acc, taken_acc, ntaken_acc;
  logic flush_fall, flush_tgt;
  logic req_fire, fire_tgt, req_busy, busy_tgt;
  logic wr_fall, wr_tgt;
  logic dec_fire, pop_fall, pop_tgt;

  logic [AW-1:0]     rsp_addr;
  logic [EW_ENT-1:0] fall_head, tgt_head, rsp_entry;
  logic [SCW-1:0]    seq_count;
  logic [TCW-1:0]    tgt_count;
  logic              fall_empty, tgt_empty;

  function automatic logic [AW-1:0] word_step(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [EPOCH_W-1:0] gen_step(input logic [EPOCH_W-1:0] g);
    return g + EPOCH_W'(1);
  endfunction

  // branch and resolve acceptance
  assign cond_acc   = br_valid &&  br_cond && !cond_pend && !drain_tgt;
  assign jump_acc   = br_valid && !br_cond && !cond_pend;
  assign taken_acc  = res_valid &&  res_taken && cond_pend;
  assign ntaken_acc = res_valid && !res_taken && cond_pend;
  assign flush_fall = jump_acc || taken_acc;
  assign flush_tgt  = cond_acc || jump_acc || ntaken_acc;

  pfu_fetch #(.AW(AW), .EW(EPOCH_W)) u_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .use_tgt      (cond_pend),
    .fall_room    (pfu_has_room(int'(seq_count), SEQ_DEPTH)),
    .tgt_room     (pfu_has_room(int'(tgt_count), TGT_DEPTH)),
    .fall_addr    (fall_addr),
    .tgt_addr     (tgt_addr),
    .fall_gen     (fall_gen),
    .tgt_gen      (tgt_gen),
    .flush_fall   (flush_fall),
    .flush_tgt    (flush_tgt),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .mem_req_valid(mem_req_valid),
    .mem_req_addr (mem_req_addr),
    .req_fire     (req_fire),
    .fire_tgt     (fire_tgt),
    .busy         (req_busy),
    .busy_tgt     (busy_tgt),
    .rsp_addr     (rsp_addr),
    .wr_fall      (wr_fall),
    .wr_tgt       (wr_tgt)
  );

  assign rsp_entry = {rsp_addr, mem_rsp_data};

  pfu_fifo #(.DEPTH(SEQ_DEPTH), .W(EW_ENT)) u_fall_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush_fall),
    .push     (wr_fall),
    .push_data(rsp_entry),
    .pop      (pop_fall),
    .head     (fall_head),
    .count    (seq_count),
    .empty    (fall_empty)
  );

  pfu_fifo #(.DEPTH(TGT_DEPTH), .W(EW_ENT)) u_tgt_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush_tgt),
    .push     (wr_tgt),
    .push_data(rsp_entry),
    .pop      (pop_tgt),
    .head     (tgt_head),
    .count    (tgt_count),
    .empty    (tgt_empty)
  );

  // decoder side
  assign dec_valid = !jump_wait && (drain_tgt ? !tgt_empty : !fall_empty);
  assign {dec_addr, dec_data} = drain_tgt ? tgt_head : fall_head;
  assign dec_fire  = dec_valid && dec_pop;
  assign pop_fall  = dec_fire && !drain_tgt;
  assign pop_tgt   = dec_fire &&  drain_tgt;

  // fetch address update
  always_comb begin
    tgt_addr_nxt = tgt_addr;
    if (cond_acc)      tgt_addr_nxt = br_target;
    else if (fire_tgt) tgt_addr_nxt = word_step(tgt_addr);

    fall_addr_nxt = fall_addr;
    if (jump_acc)                  fall_addr_nxt = br_target;
    else if (taken_acc)            fall_addr_nxt = tgt_addr_nxt;
    else if (req_fire && !fire_tgt) fall_addr_nxt = word_step(fall_addr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_pend <= 1'b0;
      drain_tgt <= 1'b0;
      jump_wait <= 1'b0;
      fall_addr <= RESET_ADDR[AW-1:0];
      tgt_addr  <= RESET_ADDR[AW-1:0];
      fall_gen  <= '0;
      tgt_gen   <= '0;
    end else begin
      fall_addr <= fall_addr_nxt;
      tgt_addr  <= tgt_addr_nxt;
      if (flush_fall) fall_gen <= gen_step(fall_gen);
      if (flush_tgt)  tgt_gen  <= gen_step(tgt_gen);

      if (cond_acc)                    cond_pend <= 1'b1;
      else if (taken_acc || ntaken_acc) cond_pend <= 1'b0;

      if (jump_acc)       drain_tgt <= 1'b0;
      else if (taken_acc) drain_tgt <= 1'b1;
      else if (drain_tgt && tgt_empty && !(req_busy && busy_tgt))
        drain_tgt <= 1'b0;

      if (jump_acc)     jump_wait <= 1'b1;
      else if (wr_fall) jump_wait <= 1'b0;
    end
  end

endmodule

// File: rtl/pfu_checker.sv
module pfu_checker #(
  parameter int  AW        = 16,
  parameter int  SEQ_DEPTH = 4,
  parameter int  TGT_DEPTH = 4,
  localparam int SCW       = $clog2(SEQ_DEPTH + 1),
  localparam int TCW       = $clog2(TGT_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_req_valid,
  input logic           mem_req_ready,
  input logic [AW-1:0]  mem_req_addr,
  input logic [AW-1:0]  br_target,
  input logic           dec_valid,
  input logic           cond_acc,
  input logic           jump_acc,
  input logic           taken_acc,
  input logic           ntaken_acc,
  input logic [SCW-1:0] seq_count,
  input logic [TCW-1:0] tgt_count
);

  p_one_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && mem_req_valid && mem_req_ready) |-> !mem_req_valid);

  p_tgt_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && cond_acc) && mem_req_valid) |-> (mem_req_addr == $past(br_target)));

  p_jump_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n && jump_acc) && mem_req_valid) |-> (mem_req_addr == $past(br_target)));

  p_jump_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && jump_acc) |-> !dec_valid);

  p_taken_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && taken_acc) |-> (seq_count == '0));

  p_nt_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n && ntaken_acc) |-> (tgt_count == '0));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_count <= SCW'(SEQ_DEPTH)) && (tgt_count <= TCW'(TGT_DEPTH)));

endmodule

bind prefetch_dual_buf pfu_checker #(
  .AW(AW), .SEQ_DEPTH(SEQ_DEPTH), .TGT_DEPTH(TGT_DEPTH)
) u_pfu_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_addr (mem_req_addr),
  .br_target    (br_target),
  .dec_valid    (dec_valid),
  .cond_acc     (cond_acc),
  .jump_acc     (jump_acc),
  .taken_acc    (taken_acc),
  .ntaken_acc   (ntaken_acc),
  .seq_count    (seq_count),
  .tgt_count    (tgt_count)
);

// File: tb/prefetch_dual_buf_tb.sv
`timescale 1ns/1ps
module prefetch_dual_buf_tb;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int SD = 4;
  localparam int TD = 4;

  // rows: {memory latency, words popped, expected last address}
  localparam int unsigned VEC [4][3] = '{
    '{1, 10, 9}, '{3, 7, 6}, '{7, 5, 4}, '{2, 12, 11}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          mem_req_valid, mem_req_ready;
  logic [AW-1:0] mem_req_addr;
  logic          mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic          br_valid = 1'b0, br_cond = 1'b0;
  logic [AW-1:0] br_target = '0;
  logic          res_valid = 1'b0, res_taken = 1'b0;
  logic          dec_valid, dec_pop = 1'b0;
  logic [AW-1:0] dec_addr;
  logic [DW-1:0] dec_data;

  prefetch_dual_buf u_dut (
    .clk(clk), .rst_n(rst_n),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .br_valid(br_valid), .br_cond(br_cond), .br_target(br_target),
    .res_valid(res_valid), .res_taken(res_taken),
    .dec_valid(dec_valid), .dec_addr(dec_addr), .dec_data(dec_data), .dec_pop(dec_pop)
  );

  int nchk = 0, nerr = 0, cyc = 0;
  int lat = 2, viol = 0, nreq = 0;
  bit done = 1'b0;
  logic [AW-1:0] rlog [256];
  logic [AW-1:0] last_addr;

  function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
    return {a ^ 16'h5A5A, a + 16'h0123};
  endfunction

  // memory model: one request at a time, fixed latency per request
  logic          mb = 1'b0;
  int            mcnt = 0;
  logic [AW-1:0] maddr = '0;
  assign mem_req_ready = 1'b1;

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (!rst_n) begin
      mb <= 1'b0;
    end else begin
      if (mb) begin
        if (mcnt <= 1) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= word_at(maddr);
          mb            <= 1'b0;
        end else mcnt <= mcnt - 1;
      end
      if (mem_req_valid && mem_req_ready) begin
        if (mb) viol++;
        if (nreq < 256) rlog[nreq] = mem_req_addr;
        nreq++;
        mb    <= 1'b1;
        maddr <= mem_req_addr;
        mcnt  <= lat;
      end
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: got %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; br_valid = 1'b0; res_valid = 1'b0; dec_pop = 1'b0;
    repeat (3) @(negedge clk);
    nreq = 0;
    rst_n = 1'b1;
  endtask

  task automatic pop_exp(input logic [AW-1:0] a, input string rq);
    int t = 0;
    while (!dec_valid && t < 300) begin
      @(negedge clk);
      t++;
    end
    chk(dec_valid && dec_addr == a && dec_data == word_at(a), rq, "decoder word",
        {16'h0, dec_addr}, {16'h0, a});
    last_addr = dec_addr;
    dec_pop = 1'b1;
    @(negedge clk);
    dec_pop = 1'b0;
  endtask

  task automatic br_pulse(input logic c, input logic [AW-1:0] t);
    br_valid = 1'b1; br_cond = c; br_target = t;
    @(negedge clk);
    br_valid = 1'b0;
  endtask

  task automatic res_pulse(input logic tk);
    res_valid = 1'b1; res_taken = tk;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  initial begin
    // R10: reset state
    lat = 2;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!dec_valid, "R10", "dec_valid in reset", {31'h0, dec_valid}, 32'h0);
    do_reset();
    chk(!dec_valid, "R10", "dec_valid after reset", {31'h0, dec_valid}, 32'h0);
    chk(mem_req_valid && mem_req_addr == 16'h0, "R10", "first request",
        {16'h0, mem_req_addr}, 32'h0);

    // R1: sequential stream under several latencies
    for (int i = 0; i < 4; i++) begin
      lat = int'(VEC[i][0]);
      do_reset();
      for (int k = 0; k < int'(VEC[i][1]); k++) pop_exp(AW'(k), "R1");
      chk(last_addr == AW'(VEC[i][2]), "R1", "last address", {16'h0, last_addr}, VEC[i][2]);
    end

    // R7: full fall-through queue stops fetching, then resumes
    lat = 1;
    do_reset();
    repeat (30) @(negedge clk);
    chk(nreq == SD, "R7", "requests when full", nreq, SD);
    chk(!mem_req_valid, "R7", "no request when full", {31'h0, mem_req_valid}, 32'h0);
    pop_exp(16'h0, "R7");
    repeat (10) @(negedge clk);
    chk(nreq == SD + 1, "R7", "refill after pop", nreq, SD + 1);

    // R2 + R3: conditional branch, taken
    lat = 2;
    do_reset();
    repeat (40) @(negedge clk);
    br_pulse(1'b1, 16'h0100);
    repeat (40) @(negedge clk);
    chk(nreq == SD + TD, "R2", "target fill count", nreq, SD + TD);
    for (int j = 0; j < TD; j++)
      chk(rlog[SD + j] == AW'(16'h0100 + j), "R2", "target request address",
          {16'h0, rlog[SD + j]}, 16'h0100 + j);
    pop_exp(16'h0000, "R2");
    repeat (10) @(negedge clk);
    chk(nreq == SD + TD, "R2", "fall-through paused", nreq, SD + TD);
    res_pulse(1'b1);
    for (int j = 0; j < 6; j++) pop_exp(AW'(16'h0100 + j), "R3");

    // R4: conditional branch, not taken
    do_reset();
    repeat (40) @(negedge clk);
    pop_exp(16'h0000, "R4");
    pop_exp(16'h0001, "R4");
    repeat (40) @(negedge clk);
    br_pulse(1'b1, 16'h0200);
    repeat (40) @(negedge clk);
    res_pulse(1'b0);
    for (int j = 2; j < 8; j++) pop_exp(AW'(j), "R4");

    // R5: unconditional jump holds the decoder until the target returns
    lat = 6;
    do_reset();
    repeat (60) @(negedge clk);
    br_pulse(1'b0, 16'h0300);
    for (int j = 0; j < 4; j++) begin
      chk(!dec_valid, "R5", "decoder held after jump", {31'h0, dec_valid}, 32'h0);
      @(negedge clk);
    end
    pop_exp(16'h0300, "R5");
    pop_exp(16'h0301, "R5");

    // R8: response in flight when the jump flushes its queue is dropped
    lat = 10;
    do_reset();
    repeat (3) @(negedge clk);
    br_pulse(1'b0, 16'h0400);
    pop_exp(16'h0400, "R8");
    pop_exp(16'h0401, "R8");

    // R9: stray resolve and a branch notice during a pending branch are ignored
    lat = 2;
    do_reset();
    repeat (40) @(negedge clk);
    res_pulse(1'b1);
    pop_exp(16'h0000, "R9");
    br_pulse(1'b1, 16'h0100);
    repeat (2) @(negedge clk);
    br_pulse(1'b0, 16'h0500);
    repeat (40) @(negedge clk);
    res_pulse(1'b1);
    pop_exp(16'h0100, "R9");
    pop_exp(16'h0101, "R9");

    // R6: memory model never saw a second request while one was outstanding
    chk(viol == 0, "R6", "overlapping requests", viol, 0);

    summary();
    $finish;
  end

endmodule